// File: doc/BRIEF.md
# Latched Interrupt Controller with Per-Source Masks

The block gathers up to fifteen level-high interrupt sources into one interrupt request for a processor. Each source owns a sticky pending flag and a mask bit. A single master enable gates the combined request. All of this state sits in one 32-bit word that software reads and writes through a single-cycle register port. Software finds the cause of an interrupt by scanning the pending flags. The block does not prioritise sources, produce vectors or handle nesting.

Pending flags are cleared by writing ones to them. A clear is refused while the source line is still high, so an interrupt that is still active cannot be lost. Mask bits change only at positions where a 1 is written. The written master bit chooses whether those masks are set or cleared, so one write can enable or disable any group of sources. The source count is the parameter `N_SRC`, from 1 to 15. Word positions with no source read as zero and ignore writes.

Top module: `irqc_latched`

## Requirements
- R1: After reset, the master enable, every mask bit and every pending flag are 0. `rd_data_o` reads 0 and `irq_o` is 0.
- R2: Every write loads the master enable (word bit 31) with bit 31 of the written data.
- R3: For source i, a write with bit 16+i equal to 1 loads mask i with written bit 31. A write with bit 16+i equal to 0 leaves mask i unchanged.
- R4: A source that is high at a clock edge sets its pending flag (bit i) at that edge. The flag stays set after the source returns low, until it is cleared.
- R5: A write with bit i equal to 1 clears pending flag i if source i is low in that cycle. A write with bit i equal to 0 leaves the flag unchanged.
- R6: A clear of pending flag i has no effect while source i is high in the same cycle.
- R7: `irq_o` is registered. At each edge it takes the value of master AND (OR over i of pending i AND mask i), computed from the state held before that edge. Read bit 15 returns `irq_o`.
- R8: The read word holds the master enable at bit 31, mask i at bit 16+i, `irq_o` at bit 15 and pending i at bit i. Positions i >= `N_SRC` read 0 and writes to them have no effect.
- R9: Writing 0x800F000F sets the master enable and masks 0 to 3, and clears pending flags 0 to 3. A later write of 0x00010001 clears mask 0, clears pending flag 0 and turns the master enable off. Masks 1 to 3 are left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data (combinational view of the state) |
| src_i | input | N_SRC | Level-high interrupt sources |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The important collision is a software clear of a pending flag that lands in the same cycle as its source line being high. The bench holds a source high across a write-one-to-clear of that flag. It then reads the flag back as still set, and shows that the same clear succeeds once the line has dropped. A second overlap is a write that changes the master enable while `irq_o` is asserted. The bench judges this against the one-cycle lag of `irq_o`: the sample right after the write still shows the old request, and the next sample shows the new one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned MAX_SRC    = 15;
  localparam int unsigned MASTER_BIT = 31;
  localparam int unsigned IRQ_BIT    = 15;
  localparam int unsigned MASK_LSB   = 16;
  localparam int unsigned PEND_LSB   = 0;
endpackage

// File: rtl/irqc_src_slice.sv
module irqc_src_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic wr_i,
  input  logic clr_i,
  input  logic mask_sel_i,
  input  logic mask_val_i,
  output logic pend_o,
  output logic mask_o
);
  logic pend_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      // an active source wins over a clear in the same cycle
      pend_q <= src_i | (pend_q & ~(wr_i & clr_i));
      if (wr_i && mask_sel_i) mask_q <= mask_val_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // R4: an active source leaves the flag set
  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i |=> pend_q);
  // R4: the flag is sticky without a clear
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(wr_i && clr_i)) |=> pend_q);
  // R5: a clear with the line low succeeds
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr_i && !src_i) |=> !pend_q);
  // R6: a clear with the line high is refused
  p_clear_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr_i && src_i) |=> pend_q);
  // R3: an unselected mask holds its value
  p_mask_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && mask_sel_i) |=> $stable(mask_q));
  // R3: a selected mask takes the written value
  p_mask_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mask_sel_i) |=> (mask_q == $past(mask_val_i)));
endmodule

// File: rtl/irqc_merge.sv
module irqc_merge #(
  parameter int unsigned N_SRC = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= master_i & (|(pend_i & mask_i));
  end

  assign irq_o = irq_q;

  // R7: no request without the master enable one cycle earlier
  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(master_i));
  // R7: an enabled pending source raises the request on the next edge
  p_irq_raise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && |(pend_i & mask_i)) |=> irq_q);
endmodule

// File: rtl/irqc_latched.sv
module irqc_latched
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic              irq_o
);
  logic             master_q;
  logic [N_SRC-1:0] pend, mask;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      master_q <= 1'b0;
    else if (wr_en_i) master_q <= wr_data_i[MASTER_BIT];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irqc_src_slice u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[i]),
      .wr_i       (wr_en_i),
      .clr_i      (wr_data_i[PEND_LSB+i]),
      .mask_sel_i (wr_data_i[MASK_LSB+i]),
      .mask_val_i (wr_data_i[MASTER_BIT]),
      .pend_o     (pend[i]),
      .mask_o     (mask[i])
    );
  end

  irqc_merge #(.N_SRC(N_SRC)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_q),
    .pend_i   (pend),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    rd_data_o[MASTER_BIT] = master_q;
    rd_data_o[IRQ_BIT]    = irq_o;
    for (int i = 0; i < N_SRC; i++) begin
      rd_data_o[MASK_LSB+i] = mask[i];
      rd_data_o[PEND_LSB+i] = pend[i];
    end
  end

  // R2: master bit follows bit 31 of every write
  p_master_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (master_q == $past(wr_data_i[MASTER_BIT])));
  // R2: master holds without a write
  p_master_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(master_q));
  // R7: read bit 15 mirrors the request output
  p_rd_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[IRQ_BIT] == irq_o);
endmodule

// File: tb/tb_irqc_latched.sv
module tb_irqc_latched;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC      = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      rd_data;
  logic [N_SRC-1:0] src = '0;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_latched #(.N_SRC(N_SRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .src_i(src), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 read word", rd_data, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_example;
    wr(32'h800F000F);
    chk("R9 first write", rd_data, 32'h800F0000);
    @(negedge clk); src = 12'h005;
    @(negedge clk); src = '0;
    chk("R4 pending set", rd_data, 32'h800F0005);
    step();
    chk("R7 irq after one cycle", rd_data, 32'h800F8005);
    chk("R7 irq pin", {31'b0, irq}, 32'h1);
    wr(32'h00010001);
    chk("R9 second write, irq lags", rd_data, 32'h000E8004);
    step();
    chk("R9 R7 master off drops irq", rd_data, 32'h000E0004);
  endtask

  task automatic t_mask_keep;
    wr(32'h00000000);
    chk("R3 zero mask bits keep masks", rd_data, 32'h000E0004);
    wr(32'h80000000);
    chk("R2 master on, R3 masks kept", rd_data, 32'h800E0004);
    step();
    chk("R7 irq from kept mask", rd_data, 32'h800E8004);
    wr(32'h80000004);
    chk("R5 clear with line low", rd_data, 32'h800E8000);
    step();
    chk("R7 irq falls after clear", rd_data, 32'h800E0000);
    wr(32'h80000000);
    chk("R5 zero write keeps clear state", rd_data, 32'h800E0000);
  endtask

  task automatic t_clear_blocked;
    @(negedge clk); src = 12'h002;
    wr(32'h00000002);
    chk("R6 clear refused while high", rd_data, 32'h000E8002);
    step();
    chk("R6 flag still set, irq off", rd_data, 32'h000E0002);
    src = '0;
    wr(32'h00000002);
    chk("R5 clear succeeds after drop", rd_data, 32'h000E0000);
  endtask

  task automatic t_sticky;
    @(negedge clk); src = 12'h008;
    @(negedge clk); src = '0;
    for (int k = 0; k < 5; k++) step();
    chk("R4 flag sticky", rd_data, 32'h000E0008);
    wr(32'h00000008);
    chk("R5 sticky flag cleared", rd_data, 32'h000E0000);
  endtask

  task automatic t_unused;
    wr(32'hFFFFFFFF);
    chk("R8 absent positions read 0", rd_data, 32'h8FFF0000);
    @(negedge clk); src = 12'h800;
    @(negedge clk); src = '0;
    chk("R8 top source at bit 11", rd_data, 32'h8FFF0800);
    step();
    chk("R8 R7 irq at bit 15", rd_data, 32'h8FFF8800);
    wr(32'h7FFF0000);
    chk("R3 all masks cleared", rd_data, 32'h00008800);
    step();
    chk("R7 no irq with masks off", rd_data, 32'h00000800);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_example();
    t_mask_keep();
    t_clear_blocked();
    t_sticky();
    t_unused();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule